// File: doc/BRIEF.md
# T1 Receive Loss-of-Signal Detector

This block sits on the receive side of a T1 line interface, after clock and data recovery. It sees one recovered bit per recovered clock on two rails, a positive mark and a negative mark, and keeps a single loss-of-signal flag. The flag is raised after a long unbroken run of zeros. It is also raised while either of two indications from the analog front end is asserted: received power below threshold, or equalizer gain at its maximum. Reset raises it too. The flag drops only after a full observation window shows enough ones density and no over-long zero run.

While the flag is up, both receive data rails leaving the block are held at zero, so downstream framing logic never sees noise decoded as data. While it is down, the rails pass through unchanged. The data path is combinational and gated by the registered flag, so the squelch covers exactly the cycles in which the flag reads high.

Top module: `t1_los_detector`

## Requirements
- R1: During and right after a synchronous active-low reset, `los_o` reads 1, and the exit window starts empty with the first bit clocked after reset is released.
- R2: With `los_o` at 0, the 175th consecutive zero bit sets `los_o` to 1 from the cycle after that bit is clocked; 174 consecutive zeros leave it at 0.
- R3: A received bit counts as a one when `pos_i` or `neg_i` is 1, so a mark on either rail alone counts for both entry and exit.
- R4: A clock edge with `low_power_i` or `max_gain_i` at 1 sets `los_o` to 1 for the next cycle. While either input is held, `los_o` stays 1 and the exit window keeps restarting.
- R5: With `los_o` at 1, the exit window is 175 consecutive bits. At the 175th bit, if the window holds 22 or more ones, `los_o` reads 0 from the next cycle. With fewer ones it stays 1 and a new window starts. `los_o` never clears before a window completes.
- R6: A zero run that reaches 101 bits during the exit window restarts the window, and the bit after the 101st zero becomes window bit 0. A run of exactly 100 zeros does not restart it.
- R7: While `los_o` is 1, `pos_o` and `neg_o` are 0 in the same cycle. While `los_o` is 0, `pos_o` equals `pos_i` and `neg_o` equals `neg_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Recovered receive clock, one bit per rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| pos_i | input | 1 | Positive-rail mark of the current bit |
| neg_i | input | 1 | Negative-rail mark of the current bit |
| low_power_i | input | 1 | Received power is below the loss threshold |
| max_gain_i | input | 1 | Receive equalizer gain is at its maximum |
| los_o | output | 1 | Loss-of-signal flag, registered |
| pos_o | output | 1 | Positive rail after squelch |
| neg_o | output | 1 | Negative rail after squelch |

## Verification
The flag is registered, so any change caused by a bit shows one cycle later. The bench drives each bit on a falling edge, lets the rising edge take it, and reads `los_o` on the following falling edge. That reading is the flag's response to that bit alone. The squelched rails are combinational, so they are read one nanosecond after the drive, before the edge that would take the bit, and are compared against the flag value already settled for that cycle. For the entry, exit and run-limit boundaries, the flag is checked after the last bit before the boundary and again after the bit that crosses it.

// File: rtl/t1_los_pkg.sv
// Package: shared line-state encoding for the loss-of-signal detector.
// Assumes: nothing beyond the consumers importing it.
package t1_los_pkg;

    // Two-state line condition held by the flag register.
    typedef enum logic {
        LINE_UP   = 1'b0,
        LINE_LOST = 1'b1
    } line_state_e;

endpackage

// File: rtl/t1_los_run_counter.sv
// Module: counts consecutive received zeros, saturating at SAT.
// It gives the run length including the current bit and a strobe that
// goes high when the run reaches SAT.
// Assumes: one bit per clock; mark_i = 1 is a received one.
module t1_los_run_counter #(
    parameter int unsigned SAT   = 175,
    parameter int unsigned RUN_W = $clog2(SAT + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mark_i,
    output logic [RUN_W-1:0] run_len_o,
    output logic             reached_o
);
    localparam logic [RUN_W-1:0] SAT_V = RUN_W'(SAT);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;

    // Next run length: a one clears it, a zero extends it up to SAT.
    always_comb begin
        if (mark_i) begin
            run_d = '0;
        end else if (run_q == SAT_V) begin
            run_d = SAT_V;
        end else begin
            run_d = run_q + 1'b1;
        end
    end

    assign run_len_o = run_d;
    assign reached_o = (run_d == SAT_V);

    // Hold the run length across bits.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // R2: the count never exceeds the saturation value.
    a_r2_run_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q <= SAT_V);

endmodule

// File: rtl/t1_los_exit_window.sv
// Module: exit test for loss of signal. While lost_i is high it collects
// WIN_LEN bits, counts the ones among them, and gives a one-cycle pass
// strobe on the last bit when at least MIN_ONES ones were seen. The
// window restarts on hold_i, on a zero run longer than MAX_RUN, or on a
// failed window.
// Assumes: run_len_i already includes the current bit.
module t1_los_exit_window #(
    parameter int unsigned WIN_LEN  = 175,
    parameter int unsigned MIN_ONES = 22,
    parameter int unsigned MAX_RUN  = 100,
    parameter int unsigned RUN_W    = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lost_i,
    input  logic             hold_i,
    input  logic             mark_i,
    input  logic [RUN_W-1:0] run_len_i,
    output logic             pass_o
);
    localparam int unsigned WIN_W  = $clog2(WIN_LEN);
    localparam int unsigned ONES_W = $clog2(WIN_LEN + 1);
    localparam logic [WIN_W-1:0]  LAST_V    = WIN_W'(WIN_LEN - 1);
    localparam logic [ONES_W-1:0] MIN_V     = ONES_W'(MIN_ONES);
    localparam logic [RUN_W-1:0]  MAX_RUN_V = RUN_W'(MAX_RUN);

    logic [WIN_W-1:0]  win_q;
    logic [ONES_W-1:0] ones_q;
    logic [ONES_W-1:0] ones_sum;
    logic              restart;
    logic              last_bit;

    // Window decisions for the current bit.
    always_comb begin
        restart  = hold_i || (run_len_i > MAX_RUN_V);
        last_bit = (win_q == LAST_V);
        ones_sum = ones_q + ONES_W'(mark_i);
        pass_o   = lost_i && !restart && last_bit && (ones_sum >= MIN_V);
    end

    // Advance the position and the ones tally, or clear them.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !lost_i || restart || last_bit) begin
            win_q  <= '0;
            ones_q <= '0;
        end else begin
            win_q  <= win_q + 1'b1;
            ones_q <= ones_sum;
        end
    end

    // R5: a window never holds more ones than bits collected.
    a_r5_ones_within_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(ones_q) <= int'(win_q));

    // R6: a position past zero implies the previous bit ended no long run.
    a_r6_window_run_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_q != '0) |-> ($past(run_len_i) <= MAX_RUN_V));

endmodule

// File: rtl/t1_los_flag.sv
// Module: loss-of-signal flag register. External indications set it,
// a zero-run strobe sets it from the up state, and the window pass
// strobe clears it from the lost state.
// Assumes: strobes are single-bit decisions for the current clock.
module t1_los_flag
    import t1_los_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_i,
    input  logic entry_i,
    input  logic pass_i,
    output logic lost_o
);
    line_state_e state_q;
    line_state_e state_d;

    // Next line state; external indications take priority.
    always_comb begin
        state_d = state_q;
        if (ext_i) begin
            state_d = LINE_LOST;
        end else if (state_q == LINE_LOST && pass_i) begin
            state_d = LINE_UP;
        end else if (state_q == LINE_UP && entry_i) begin
            state_d = LINE_LOST;
        end
    end

    // State register; reset declares loss.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= LINE_LOST;
        end else begin
            state_q <= state_d;
        end
    end

    assign lost_o = (state_q == LINE_LOST);

    // R4: an external indication forces loss on the next cycle.
    a_r4_ext_forces_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_i |=> lost_o);

    // R1: reset leaves the flag raised.
    a_r1_reset_raises: assert property (@(posedge clk_i)
        !rst_ni |=> lost_o);

endmodule

// File: rtl/t1_los_squelch.sv
// Module: gates each receive rail with the loss flag.
// Assumes: lost_i is a registered flag, so the gating is glitch-free.
module t1_los_squelch #(
    parameter int unsigned RAILS = 2
) (
    input  logic             lost_i,
    input  logic [RAILS-1:0] rail_i,
    output logic [RAILS-1:0] rail_o
);
    // One AND gate per rail.
    for (genvar g = 0; g < RAILS; g++) begin : g_rail
        assign rail_o[g] = rail_i[g] & ~lost_i;
    end

endmodule

// File: rtl/t1_los_detector.sv
// Module: top of the T1 receive loss-of-signal detector. It joins the
// zero-run counter, the exit window, the flag register and the rail
// squelch.
// Assumes: clk_i is the recovered clock and one bit arrives per edge.
module t1_los_detector #(
    parameter int unsigned ENTRY_ZEROS = 175,
    parameter int unsigned WIN_LEN     = 175,
    parameter int unsigned MIN_ONES    = 22,
    parameter int unsigned MAX_RUN     = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pos_i,
    input  logic neg_i,
    input  logic low_power_i,
    input  logic max_gain_i,
    output logic los_o,
    output logic pos_o,
    output logic neg_o
);
    localparam int unsigned RAILS = 2;
    localparam int unsigned RUN_W = $clog2(ENTRY_ZEROS + 1);
    localparam logic [RUN_W-1:0] MAX_RUN_V = RUN_W'(MAX_RUN);

    logic             mark;
    logic             ext;
    logic             entry;
    logic             pass;
    logic [RUN_W-1:0] run_len;
    logic [RAILS-1:0] rails_in;
    logic [RAILS-1:0] rails_out;

    // A mark on either rail is a one; either front-end indication is loss.
    always_comb begin
        mark     = pos_i | neg_i;
        ext      = low_power_i | max_gain_i;
        rails_in = {neg_i, pos_i};
    end

    t1_los_run_counter #(
        .SAT   (ENTRY_ZEROS),
        .RUN_W (RUN_W)
    ) u_run (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mark_i    (mark),
        .run_len_o (run_len),
        .reached_o (entry)
    );

    t1_los_exit_window #(
        .WIN_LEN  (WIN_LEN),
        .MIN_ONES (MIN_ONES),
        .MAX_RUN  (MAX_RUN),
        .RUN_W    (RUN_W)
    ) u_win (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lost_i    (los_o),
        .hold_i    (ext),
        .mark_i    (mark),
        .run_len_i (run_len),
        .pass_o    (pass)
    );

    t1_los_flag u_flag (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ext_i   (ext),
        .entry_i (entry),
        .pass_i  (pass),
        .lost_o  (los_o)
    );

    t1_los_squelch #(
        .RAILS (RAILS)
    ) u_sq (
        .lost_i (los_o),
        .rail_i (rails_in),
        .rail_o (rails_out)
    );

    assign pos_o = rails_out[0];
    assign neg_o = rails_out[1];

    // R2: a full zero run while up raises the flag next cycle.
    a_r2_entry_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!los_o && entry) |=> los_o);

    // R4: the flag never drops on a cycle that had an external indication.
    a_r4_exit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(los_o) |-> $past(!low_power_i && !max_gain_i));

    // R6: the bit that completed an exit did not end a run longer than the limit.
    a_r6_exit_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(los_o) |-> ($past(run_len) <= MAX_RUN_V));

    // R7: both rails are quiet while the flag is raised.
    a_r7_squelch_rails: assert property (@(posedge clk_i) disable iff (!rst_ni)
        los_o |-> (!pos_o && !neg_o));

endmodule

// File: tb/t1_los_detector_tb.sv
module t1_los_detector_tb;

    localparam int WIN   = 175;
    localparam int NEED  = 22;
    localparam int ENTRY = 175;
    localparam int LIMIT = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos_i = 1'b0;
    logic neg_i = 1'b0;
    logic lp_i = 1'b0;
    logic mg_i = 1'b0;
    logic los_o, pos_o, neg_o;
    logic comb_pos, comb_neg;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    t1_los_detector u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pos_i       (pos_i),
        .neg_i       (neg_i),
        .low_power_i (lp_i),
        .max_gain_i  (mg_i),
        .los_o       (los_o),
        .pos_o       (pos_o),
        .neg_o       (neg_o)
    );

    always #4 clk = ~clk;

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    // Watchdog: an overrun counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
            report();
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Starts and ends on a falling edge; captures the squelched rails before the edge.
    task automatic send_bit(input logic p, input logic n, input logic lp, input logic mg);
        pos_i = p; neg_i = n; lp_i = lp; mg_i = mg;
        #1;
        comb_pos = pos_o;
        comb_neg = neg_o;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        pos_i = 0; neg_i = 0; lp_i = 0; mg_i = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1", "flag in reset", los_o, 1);
        rst_n = 1;
    endtask

    // Window bit i of a pattern with n ones spaced seven apart.
    function automatic logic spaced(input int i, input int n);
        return (i % 7 == 0) && (i / 7 < n);
    endfunction

    initial begin
        @(negedge clk);
        do_reset();
        // R7: rails are squelched right after reset.
        pos_i = 1; neg_i = 1;
        #1;
        check("R7", "pos squelched after reset", pos_o, 0);
        check("R7", "neg squelched after reset", neg_o, 0);
        pos_i = 0; neg_i = 0;

        // R5: sweep ones density around the exit threshold.
        for (int n = 18; n <= 25; n++) begin
            do_reset();
            for (int i = 0; i < WIN - 1; i++) send_bit(spaced(i, n), 0, 0, 0);
            check("R5", $sformatf("held before window end n=%0d", n), los_o, 1);
            send_bit(spaced(WIN - 1, n), 0, 0, 0);
            check("R5", $sformatf("exit at window end n=%0d", n), los_o, (n >= NEED) ? 1'b0 : 1'b1);
        end

        // R3: marks on the negative rail alone count as ones.
        do_reset();
        for (int i = 0; i < WIN; i++) send_bit(0, spaced(i, 25), 0, 0);
        check("R3", "exit on negative marks", los_o, 0);

        // R6: a run of exactly 100 zeros keeps the window.
        do_reset();
        for (int i = 0; i < 30; i++) send_bit(1, 0, 0, 0);
        for (int i = 0; i < 100; i++) send_bit(0, 0, 0, 0);
        for (int i = 0; i < 45; i++) send_bit(1, 0, 0, 0);
        check("R6", "100-zero run allowed", los_o, 0);

        // R6: a run of 101 zeros restarts the window.
        do_reset();
        for (int i = 0; i < 30; i++) send_bit(1, 0, 0, 0);
        for (int i = 0; i < 101; i++) send_bit(0, 0, 0, 0);
        for (int i = 0; i < 44; i++) send_bit(1, 0, 0, 0);
        check("R6", "101-zero run restarts", los_o, 1);
        for (int i = 44; i < WIN - 1; i++) send_bit(spaced(i, 40), 0, 0, 0);
        check("R6", "held before new window end", los_o, 1);
        send_bit(spaced(WIN - 1, 40), 0, 0, 0);
        check("R6", "exit at new window end", los_o, 0);

        // R7: pass-through while the flag is down.
        send_bit(1, 0, 0, 0);
        check("R7", "pos passes", comb_pos, 1);
        check("R7", "neg idle", comb_neg, 0);
        send_bit(0, 1, 0, 0);
        check("R7", "neg passes", comb_neg, 1);

        // R2: entry on the 175th consecutive zero.
        for (int i = 0; i < ENTRY - 1; i++) send_bit(0, 0, 0, 0);
        check("R2", "174 zeros keep flag low", los_o, 0);
        send_bit(0, 0, 0, 0);
        check("R2", "175th zero raises flag", los_o, 1);
        send_bit(1, 1, 0, 0);
        check("R7", "pos squelched when lost", comb_pos, 0);
        check("R7", "neg squelched when lost", comb_neg, 0);

        // R4: low-power indication from the up state.
        do_reset();
        for (int i = 0; i < WIN; i++) send_bit(1, 0, 0, 0);
        check("R5", "all-ones window exits", los_o, 0);
        send_bit(1, 0, 1, 0);
        check("R4", "low power raises flag", los_o, 1);
        for (int i = 0; i < 200; i++) send_bit(1, 0, 0, 1);
        check("R4", "max gain held keeps flag", los_o, 1);
        for (int i = 0; i < WIN - 1; i++) send_bit(1, 0, 0, 0);
        check("R4", "window restarts after release", los_o, 1);
        send_bit(1, 0, 0, 0);
        check("R4", "exit one window after release", los_o, 0);
        send_bit(0, 1, 0, 1);
        check("R4", "max gain raises flag", los_o, 1);

        report();
        $finish;
    end

endmodule